// File: doc/BRIEF.md
# Real-Time Counter with Coherent Shadow Read

This block keeps wall-clock time as a 32-bit seconds count and a milliseconds count. The time base is a free-running 32.768 kHz slow clock. The slow clock is sampled by the bus clock, and each rising edge becomes a single-cycle tick enable. A fractional accumulator turns 32768 ticks per second into 1000 millisecond steps without drift. When the milliseconds count wraps, the seconds count advances.

Software does not see the live counters. After every eighth slow tick, the block copies the live values into bus-visible registers. A busy flag is raised for a fixed number of bus cycles during that copy. Reading the milliseconds register also latches the published seconds into a shadow register in the same access. A following read of the shadow register therefore returns seconds that match the milliseconds already read.

Software can load a new seconds value. If the load arrives while the copy is in progress, the block holds it and applies it when the copy finishes, so the load is neither lost nor overwritten by the copy.

Top module: `rtc_shadow_timekeeper`

## Requirements
- R1: After a synchronous reset, the busy flag, the published seconds, the published milliseconds and the shadow seconds all read zero.
- R2: Each rising edge of `slow_clk_i` adds MS_PER_SEC (default 1000) to an accumulator taken modulo TICKS_PER_SEC (default 32768). Each time the accumulator wraps, the millisecond count advances by one. A slow clock held at a steady level advances nothing.
- R3: The millisecond count runs from 0 to MS_PER_SEC-1. Its wrap back to 0 increments the 32-bit seconds count, which itself wraps from 0xFFFFFFFF to 0.
- R4: The published seconds and milliseconds take new live values only when a copy completes. A copy starts on every COPY_DIV-th slow tick (default 8), counted from reset. Between copies, reads return the previously published values.
- R5: Bit 0 of the register at byte address 0x04 is the busy flag and all its other bits read 0. The flag stays high for exactly BUSY_CYCLES consecutive bus cycles per copy (default 4) and rises only after a slow tick.
- R6: The register at 0x08 returns the published seconds, 0x0C returns the shadow seconds and 0x10 returns the published milliseconds, zero-extended. Every other address reads 0.
- R7: A read at 0x10 copies the published seconds into the shadow register at the clock edge that ends the access. No other event, including a seconds write, changes the shadow register.
- R8: A write to 0x08 while busy is low loads the live seconds count and the published seconds at once.
- R9: A write to 0x08 while busy is high is held. It is applied to both the live and the published seconds when the copy completes. Until then, 0x08 still returns the old published value.
- R10: Writes to any address other than 0x08 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_i | input | 1 | 32.768 kHz time base, asynchronous to `clk` |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the selected register |

## Verification
The slow clock is given in bursts whose lengths are chosen either at random or deliberately short of a copy boundary. This separates the live counter from the published copy. A stale value after seven ticks shows the published registers are not wired to the live counters. The bench runs with a reduced tick-to-millisecond ratio so that the fractional accumulator and the seconds carry are reached, including the 32-bit wrap. Seconds writes are issued both while the copy is idle and in the middle of the busy window, which separates an immediate load from a deferred one. Millisecond-then-shadow read pairs, interleaved with seconds writes, show that only a milliseconds read moves the shadow register.

// File: rtl/rtc_tk_pkg.sv
// Package: shared constants and register decode for the real-time counter.
// Assumes byte addressing with 32-bit registers at word-aligned offsets.
package rtc_tk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSEC   = 8'h10;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_BUSY,
        RSEL_SEC,
        RSEL_SHADOW,
        RSEL_MSEC
    } reg_sel_e;

    // Maps a byte address onto the register it selects.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_BUSY:   return RSEL_BUSY;
            OFS_SEC:    return RSEL_SEC;
            OFS_SHADOW: return RSEL_SHADOW;
            OFS_MSEC:   return RSEL_MSEC;
            default:    return RSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_sync.sv
// Module: brings the asynchronous slow clock into the bus domain and emits a
// one-cycle tick for each rising edge.
// Assumes the slow clock's high and low phases each last at least
// SYNC_STAGES+1 bus cycles.
module rtc_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the slow level through the synchronizer; remember the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], slow_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising-edge detect on the synchronized level.
    always_comb tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/rtc_time_core.sv
// Module: live time counters. A fractional accumulator converts slow ticks into
// millisecond steps; a millisecond wrap carries into the seconds count.
// Assumes MS_PER_SEC < TICKS_PER_SEC, so one tick gives at most one step.
// A seconds load takes priority over a carry in the same cycle.
module rtc_time_core #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int MS_PER_SEC    = 1000,
    parameter int SEC_W         = 32,
    parameter int MS_W          = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_val_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [MS_W-1:0]  ms_o
);

    localparam int ACC_W = $clog2(TICKS_PER_SEC + MS_PER_SEC) + 1;
    localparam logic [ACC_W-1:0] ACC_ADD  = ACC_W'(MS_PER_SEC);
    localparam logic [ACC_W-1:0] ACC_MOD  = ACC_W'(TICKS_PER_SEC);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_PER_SEC - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_nxt;
    logic             ms_step;
    logic             ms_wrap;
    logic [MS_W-1:0]  ms_q;
    logic [SEC_W-1:0] sec_q;

    // Next accumulator value and whether this tick yields a millisecond.
    always_comb begin
        acc_sum = acc_q + ACC_ADD;
        ms_step = (acc_sum >= ACC_MOD);
        acc_nxt = ms_step ? (acc_sum - ACC_MOD) : acc_sum;
        ms_wrap = ms_step && (ms_q == MS_LAST);
    end

    // Advance accumulator and milliseconds on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ms_q  <= '0;
        end else if (tick_i) begin
            acc_q <= acc_nxt;
            if (ms_wrap)
                ms_q <= '0;
            else if (ms_step)
                ms_q <= ms_q + 1'b1;
        end
    end

    // Seconds: software load first, then carry from a millisecond wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= '0;
        else if (load_i)
            sec_q <= load_val_i;
        else if (tick_i && ms_wrap)
            sec_q <= sec_q + 1'b1;
    end

    assign sec_o = sec_q;
    assign ms_o  = ms_q;

endmodule

// File: rtl/rtc_publisher.sv
// Module: schedules the periodic copy of the live time into the bus-visible
// registers, drives the busy flag and arbitrates seconds writes against it.
// Assumes a copy finishes before the next COPY_DIV-th tick; a start that
// arrives while busy is dropped.
module rtc_publisher #(
    parameter int COPY_DIV    = 8,
    parameter int BUSY_CYCLES = 4,
    parameter int SEC_W       = 32,
    parameter int MS_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] core_sec_i,
    input  logic [MS_W-1:0]  core_ms_i,
    input  logic             wr_sec_i,
    input  logic [SEC_W-1:0] wr_data_i,
    output logic             busy_o,
    output logic [SEC_W-1:0] pub_sec_o,
    output logic [MS_W-1:0]  pub_ms_o,
    output logic             load_o,
    output logic [SEC_W-1:0] load_val_o
);

    localparam int PH_W = (COPY_DIV > 1) ? $clog2(COPY_DIV) : 1;
    localparam int BC_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(COPY_DIV - 1);
    localparam logic [BC_W-1:0] BC_START = BC_W'(BUSY_CYCLES - 1);

    logic [PH_W-1:0]  phase_q;
    logic [BC_W-1:0]  cnt_q;
    logic             busy_q;
    logic             pend_q;
    logic [SEC_W-1:0] pend_val_q;
    logic [SEC_W-1:0] pub_sec_q;
    logic [MS_W-1:0]  pub_ms_q;
    logic             start;
    logic             done;

    // Copy boundary and copy completion for this cycle.
    always_comb begin
        start = tick_i && (phase_q == PH_LAST);
        done  = busy_q && (cnt_q == '0);
    end

    // Seconds load: immediate when idle or at completion, else the held value.
    always_comb begin
        if (wr_sec_i) begin
            load_o     = !busy_q || done;
            load_val_o = wr_data_i;
        end else begin
            load_o     = done && pend_q;
            load_val_o = pend_val_q;
        end
    end

    // Count slow ticks modulo COPY_DIV from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (tick_i)
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    // Busy window: BUSY_CYCLES bus cycles starting after a copy boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (done)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= BC_START;
        end
    end

    // Hold a seconds write that lands inside the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
        end else if (done) begin
            pend_q <= 1'b0;
        end else if (busy_q && wr_sec_i) begin
            pend_q     <= 1'b1;
            pend_val_q <= wr_data_i;
        end
    end

    // Published registers: load from software, or copy live time at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_sec_q <= '0;
            pub_ms_q  <= '0;
        end else begin
            if (load_o)
                pub_sec_q <= load_val_o;
            else if (done)
                pub_sec_q <= core_sec_i;
            if (done)
                pub_ms_q <= core_ms_i;
        end
    end

    assign busy_o    = busy_q;
    assign pub_sec_o = pub_sec_q;
    assign pub_ms_o  = pub_ms_q;

endmodule

// File: rtl/rtc_shadow_timekeeper.sv
// Module: top of the real-time counter. Ties the slow-clock synchronizer, the
// live counters and the copy scheduler to a simple register port. A
// milliseconds read latches the published seconds into the shadow register.
// Assumes single-cycle accesses; read data is combinational.
module rtc_shadow_timekeeper #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int MS_PER_SEC    = 1000,
    parameter int COPY_DIV      = 8,
    parameter int BUSY_CYCLES   = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             slow_clk_i,
    input  logic                             bus_sel_i,
    input  logic                             bus_we_i,
    input  logic [rtc_tk_pkg::ADDR_W-1:0]    bus_addr_i,
    input  logic [rtc_tk_pkg::DATA_W-1:0]    bus_wdata_i,
    output logic [rtc_tk_pkg::DATA_W-1:0]    bus_rdata_o
);

    import rtc_tk_pkg::*;

    localparam int SEC_W = DATA_W;
    localparam int MS_W  = $clog2(MS_PER_SEC);

    logic             tick;
    logic             busy;
    logic             load;
    logic [SEC_W-1:0] load_val;
    logic [SEC_W-1:0] core_sec;
    logic [MS_W-1:0]  core_ms;
    logic [SEC_W-1:0] pub_sec;
    logic [MS_W-1:0]  pub_ms;
    logic [SEC_W-1:0] shadow_q;
    reg_sel_e         rsel;
    logic             wr_sec;
    logic             rd_ms;

    rtc_tick_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .slow_i (slow_clk_i),
        .tick_o (tick)
    );

    rtc_time_core #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .MS_PER_SEC   (MS_PER_SEC),
        .SEC_W        (SEC_W),
        .MS_W         (MS_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (load_val),
        .sec_o      (core_sec),
        .ms_o       (core_ms)
    );

    rtc_publisher #(
        .COPY_DIV   (COPY_DIV),
        .BUSY_CYCLES(BUSY_CYCLES),
        .SEC_W      (SEC_W),
        .MS_W       (MS_W)
    ) pub_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .core_sec_i (core_sec),
        .core_ms_i  (core_ms),
        .wr_sec_i   (wr_sec),
        .wr_data_i  (bus_wdata_i),
        .busy_o     (busy),
        .pub_sec_o  (pub_sec),
        .pub_ms_o   (pub_ms),
        .load_o     (load),
        .load_val_o (load_val)
    );

    // Decode the access into a seconds write or a milliseconds read.
    always_comb begin
        rsel   = decode_addr(bus_addr_i);
        wr_sec = bus_sel_i && bus_we_i && (rsel == RSEL_SEC);
        rd_ms  = bus_sel_i && !bus_we_i && (rsel == RSEL_MSEC);
    end

    // Shadow seconds: capture the published seconds on a milliseconds read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (rd_ms)
            shadow_q <= pub_sec;
    end

    // Read data multiplexer.
    always_comb begin
        case (rsel)
            RSEL_BUSY:   bus_rdata_o = {{(DATA_W-1){1'b0}}, busy};
            RSEL_SEC:    bus_rdata_o = pub_sec;
            RSEL_SHADOW: bus_rdata_o = shadow_q;
            RSEL_MSEC:   bus_rdata_o = DATA_W'(pub_ms);
            default:     bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_tk_checker.sv
// Module: temporal checks on the real-time counter, attached by bind.
// Assumes it sees the top's internal tick, busy, published and shadow values.
module rtc_tk_checker #(
    parameter int BUSY_CYCLES = 4,
    parameter int MS_PER_SEC  = 1000,
    parameter int MS_W        = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            busy,
    input logic [31:0]     pub_sec,
    input logic [MS_W-1:0] pub_ms,
    input logic [31:0]     shadow,
    input logic            ms_rd
);

    int run_q;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            run_q <= 0;
        else if (run_q < BUSY_CYCLES + 2)
            run_q <= run_q + 1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && pub_sec == 32'd0 && pub_ms == '0 && shadow == 32'd0));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < BUSY_CYCLES));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));

    // R4
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pub_ms) |-> $fell(busy));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow) |-> $past(ms_rd));

    // R3
    ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pub_ms) < MS_PER_SEC);

endmodule

bind rtc_shadow_timekeeper rtc_tk_checker #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .MS_PER_SEC (MS_PER_SEC),
    .MS_W       (MS_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .busy    (busy),
    .pub_sec (pub_sec),
    .pub_ms  (pub_ms),
    .shadow  (shadow_q),
    .ms_rd   (rd_ms)
);

// File: tb/rtc_shadow_timekeeper_tb_top.sv
module rtc_shadow_timekeeper_tb_top;

    localparam int CLK_P  = 10;
    localparam int TPS    = 64;
    localparam int MPS    = 10;
    localparam int DIV    = 8;
    localparam int BCYC   = 4;
    localparam logic [7:0] A_BUSY = 8'h04;
    localparam logic [7:0] A_SEC  = 8'h08;
    localparam logic [7:0] A_SHD  = 8'h0C;
    localparam logic [7:0] A_MS   = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    int          m_acc = 0;
    int          m_ms = 0;
    logic [31:0] m_sec = '0;
    int          m_phase = 0;
    int          m_pub_ms = 0;
    logic [31:0] m_pub_sec = '0;
    logic [31:0] m_shadow = '0;

    always #(CLK_P/2) clk = ~clk;

    rtc_shadow_timekeeper #(
        .TICKS_PER_SEC(TPS),
        .MS_PER_SEC   (MPS),
        .COPY_DIV     (DIV),
        .BUSY_CYCLES  (BCYC),
        .SYNC_STAGES  (2)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_clk_i  (slow),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model of one slow tick, from R2, R3 and R4.
    task automatic model_tick();
        m_acc += MPS;
        if (m_acc >= TPS) begin
            m_acc -= TPS;
            if (m_ms == MPS - 1) begin
                m_ms = 0;
                m_sec = m_sec + 32'd1;
            end else begin
                m_ms++;
            end
        end
        m_phase++;
        if (m_phase == DIV) begin
            m_phase = 0;
            m_pub_ms = m_ms;
            m_pub_sec = m_sec;
        end
    endtask

    task automatic slow_pulse();
        @(negedge clk) slow = 1'b1;
        repeat (3) @(negedge clk);
        slow = 1'b0;
        repeat (3) @(negedge clk);
        model_tick();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) slow_pulse();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #(CLK_P/4) d = rdata;
        @(negedge clk);
        sel = 1'b0;
        if (a == A_MS) m_shadow = m_pub_sec;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        bus_read(A_BUSY, d);   check({req, " busy"}, d, 32'd0);
        bus_read(A_SEC, d);    check({req, " sec"}, d, m_pub_sec);
        bus_read(A_SHD, d);    check({req, " shadow"}, d, m_shadow);
        bus_read(A_MS, d);     check({req, " ms"}, d, 32'(m_pub_ms));
        bus_read(A_SHD, d);    check({req, " shadow after ms read"}, d, m_shadow);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] old_sec;
        int busy_cnt;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(A_BUSY, d); check("R1 busy", d, 32'd0);
        bus_read(A_SEC, d);  check("R1 sec", d, 32'd0);
        bus_read(A_SHD, d);  check("R1 shadow", d, 32'd0);
        bus_read(A_MS, d);   check("R1 ms", d, 32'd0);
        // R6: unmapped address reads zero
        bus_read(8'h20, d);  check("R6 unmapped", d, 32'd0);

        // R4: seven ticks leave the published ms stale although the live ms moved
        pulses(7);
        bus_read(A_MS, d);   check("R4 stale ms", d, 32'd0);
        pulses(1);
        // R2: eighth tick publishes one millisecond
        bus_read(A_MS, d);   check("R2 ms after 8 ticks", d, 32'd1);
        check_all("R2");

        // R5: busy window length and encoding
        pulses(7);
        busy_cnt = 0;
        fork
            slow_pulse();
            begin
                @(negedge clk);
                sel = 1'b1; we = 1'b0; addr = A_BUSY;
                for (int i = 0; i < 30; i++) begin
                    #(CLK_P/4);
                    if (rdata != 32'd0) begin
                        busy_cnt++;
                        check("R5 busy encoding", rdata, 32'd1);
                    end
                    @(negedge clk);
                end
                sel = 1'b0;
            end
        join
        check("R5 busy cycles", 32'(busy_cnt), 32'(BCYC));
        repeat (10) @(negedge clk);
        check_all("R4");

        // R9: seconds write during busy is held until the copy ends
        pulses(7);
        old_sec = m_pub_sec;
        fork
            slow_pulse();
            begin
                for (int i = 0; i < 30; i++) begin
                    @(negedge clk);
                    sel = 1'b1; we = 1'b0; addr = A_BUSY;
                    #(CLK_P/4);
                    if (rdata[0]) break;
                end
                @(negedge clk);
                we = 1'b1; addr = A_SEC; wdata = 32'hCAFE_0001;
                @(negedge clk);
                we = 1'b0; addr = A_SEC;
                #(CLK_P/4) d = rdata;
                @(negedge clk);
                sel = 1'b0;
            end
        join
        check("R9 old sec while busy", d, old_sec);
        repeat (10) @(negedge clk);
        m_sec = 32'hCAFE_0001;
        m_pub_sec = 32'hCAFE_0001;
        bus_read(A_SEC, d);  check("R9 held write applied", d, 32'hCAFE_0001);

        // R8 and R3: idle write near the top, then carry wraps seconds to zero
        bus_write(A_SEC, 32'hFFFF_FFFF);
        m_sec = 32'hFFFF_FFFF;
        m_pub_sec = 32'hFFFF_FFFF;
        bus_read(A_SEC, d);  check("R8 idle write", d, 32'hFFFF_FFFF);
        for (int g = 0; g < 20 && m_pub_sec != 32'd0; g++) pulses(DIV);
        bus_read(A_SEC, d);  check("R3 seconds wrap", d, 32'd0);
        check_all("R3");

        // R7: a seconds write leaves shadow alone; a ms read refreshes it
        bus_write(A_SEC, 32'h0000_1234);
        m_sec = 32'h0000_1234;
        m_pub_sec = 32'h0000_1234;
        bus_read(A_SHD, d);  check("R7 shadow unchanged by write", d, m_shadow);
        bus_read(A_MS, d);
        bus_read(A_SHD, d);  check("R7 shadow after ms read", d, 32'h0000_1234);

        // R10: writes elsewhere change nothing
        bus_write(A_MS, 32'h0000_0007);
        bus_write(A_SHD, 32'hDEAD_BEEF);
        bus_write(A_BUSY, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'h1111_1111);
        bus_read(A_SHD, d);  check("R10 shadow", d, m_shadow);
        bus_read(A_SEC, d);  check("R10 sec", d, m_pub_sec);
        bus_read(A_BUSY, d); check("R10 busy", d, 32'd0);
        bus_read(A_MS, d);   check("R10 ms", d, 32'(m_pub_ms));

        // Random mix: bursts of ticks, idle writes, coherent read pairs (R2 R4 R7 R8)
        for (int it = 0; it < 40; it++) begin
            int op;
            op = int'($urandom_range(0, 2));
            if (op == 0) begin
                pulses(int'($urandom_range(1, 12)));
                bus_read(A_MS, d);  check("R4 random ms", d, 32'(m_pub_ms));
            end else if (op == 1) begin
                d = $urandom();
                bus_write(A_SEC, d);
                m_sec = d;
                m_pub_sec = d;
                bus_read(A_SEC, d); check("R8 random write", d, m_pub_sec);
            end else begin
                check_all("R7 random");
            end
        end
        check_all("R2 final");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule